// File: doc/BRIEF.md
# NAND Sector Hamming Syndrome Corrector

This block checks one 512-byte NAND sector after a read. It receives two 24-bit Hamming codes for the sector. The first is the code that was written into the spare area of the flash. The second is the code that the sector logic recomputed over the data just read. Each code arrives as three bytes, with byte 0 as the least significant. Both codes use the packed, inverted layout, so an erased sector yields a matching pair. One start strobe loads both codes.

The block XORs the two codes to form a syndrome and sorts the result into one of four classes:

- clean: the syndrome is zero.
- a single flipped data bit: the two 12-bit halves of the syndrome are exact complements, and the encoded byte offset lies inside the sector.
- a single flipped bit inside the stored code: the syndrome has exactly one bit set.
- uncorrectable: anything else.

For a data-bit error the block reports the byte offset and a one-hot bit mask. When the apply input is set, it also repairs the byte. It does this with a read-modify-write over a byte-wide sector buffer port that has one cycle of read latency. A one-cycle done pulse closes every request.

Top module: `nand_ecc_corrector`

## Requirements
- R1: Each code is assembled from its three input bytes with element [0] as bits [7:0], [1] as bits [15:8] and [2] as bits [23:16].
- R2: A syndrome of zero gives status 2'b00 with byte index 0 and mask 0, and it causes no buffer access.
- R3: When syndrome[11:0] XOR syndrome[23:12] equals 12'hFFF and the offset syndrome[23:15] is below SECTOR_BYTES, the status is 2'b01, byte_idx_o is syndrome[23:15] and bit_mask_o is 1 shifted left by syndrome[14:12].
- R4: A complementary-halves syndrome whose offset is at or above SECTOR_BYTES gives status 2'b11.
- R5: A syndrome with exactly one bit set gives status 2'b10 with index 0 and mask 0, and it causes no buffer access.
- R6: Any other nonzero syndrome gives status 2'b11 with index 0 and mask 0.
- R7: With apply_i high and status 2'b01, the read strobe is high in the first cycle after the accepting edge, with the address set to the byte index. In the second cycle the write strobe is high at the same address, and the write data is the read data XOR the mask. done_o is high in the third cycle. Without a repair, done_o is high in the first cycle after the accepting edge.
- R8: status_o, byte_idx_o and bit_mask_o hold their values until the next accepted start. done_o lasts one cycle per request.
- R9: A start strobe while busy_o is high is ignored: the results, the buffer sequence and the done pulse are unaffected.
- R10: After reset, status is 2'b00, done_o and busy_o are low, and neither buffer strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, loads both codes |
| apply_i | input | 1 | Repair the data byte in the buffer when a data-bit error is found |
| stored_ecc_i | input | 3x8 | Code read from the spare area, byte [0] least significant |
| calc_ecc_i | input | 3x8 | Code recomputed over the sector, byte [0] least significant |
| status_o | output | 2 | 00 clean, 01 data bit fixed, 10 code bit bad, 11 uncorrectable |
| byte_idx_o | output | 9 | Offset of the erroneous byte |
| bit_mask_o | output | 8 | One-hot mask of the erroneous bit |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Repair in progress |
| buf_addr_o | output | 9 | Sector buffer byte address |
| buf_rd_o | output | 1 | Sector buffer read strobe |
| buf_rdata_i | input | 8 | Sector buffer read data, valid one cycle after the read strobe |
| buf_wr_o | output | 1 | Sector buffer write strobe |
| buf_wdata_o | output | 8 | Sector buffer write data |

## Verification
The bench builds the block with SECTOR_BYTES set to 384 instead of 512. With 512, every 9-bit offset falls inside the sector, so the out-of-range branch could never be reached. With 384, offsets from 384 to 511 take the uncorrectable path, and offset 383 exercises the last valid byte. The bench also drives a start strobe during the read cycle of a repair, and it sends a request in the same cycle as a done pulse.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int ECC_BYTES = 3;
  localparam int ECC_W     = 8 * ECC_BYTES;
  localparam int HALF_W    = ECC_W / 2;
  localparam int BIT_W     = 3;
  localparam int OFS_W     = ECC_W - HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_DATA   = 2'b01,
    ST_ECC    = 2'b10,
    ST_UNCORR = 2'b11
  } ecc_status_e;

  typedef struct packed {
    ecc_status_e      status;
    logic [OFS_W-1:0] idx;
    logic [7:0]       mask;
  } ecc_verdict_t;
endpackage

// File: rtl/ecc_syndrome.sv
module ecc_syndrome
  import nand_ecc_pkg::*;
(
  input  logic [ECC_BYTES-1:0][7:0] stored_i,
  input  logic [ECC_BYTES-1:0][7:0] calc_i,
  output logic [ECC_W-1:0]          syn_o
);
  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_byte
    assign syn_o[8*g +: 8] = stored_i[g] ^ calc_i[g];
  end
endmodule

// File: rtl/ecc_classify.sv
module ecc_classify
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic [ECC_W-1:0] syn_i,
  output ecc_verdict_t     verdict_o
);
  localparam logic [OFS_W:0] LIMIT = SECTOR_BYTES[OFS_W:0];

  logic [HALF_W-1:0] lo, hi;
  logic [OFS_W-1:0]  ofs;
  logic [BIT_W-1:0]  bit_pos;

  assign lo      = syn_i[HALF_W-1:0];
  assign hi      = syn_i[ECC_W-1:HALF_W];
  assign ofs     = syn_i[ECC_W-1 -: OFS_W];
  assign bit_pos = syn_i[HALF_W +: BIT_W];

  always_comb begin
    verdict_o = '{status: ST_CLEAN, idx: '0, mask: '0};
    if (syn_i == '0) begin
      verdict_o.status = ST_CLEAN;
    end else if ((lo ^ hi) == '1) begin
      if ({1'b0, ofs} < LIMIT) begin
        verdict_o.status = ST_DATA;
        verdict_o.idx    = ofs;
        verdict_o.mask   = 8'b1 << bit_pos;
      end else begin
        verdict_o.status = ST_UNCORR;
      end
    end else if ($onehot(syn_i)) begin
      verdict_o.status = ST_ECC;
    end else begin
      verdict_o.status = ST_UNCORR;
    end
  end

  // R3: a data verdict always names exactly one bit
  always_comb begin
    if (verdict_o.status == ST_DATA)
      a_r3_mask_onehot : assert ($countones(verdict_o.mask) == 1);
  end
endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import nand_ecc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             fix_i,
  input  logic [OFS_W-1:0] idx_i,
  input  logic [7:0]       mask_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [OFS_W-1:0] buf_addr_o,
  output logic             buf_rd_o,
  input  logic [7:0]       buf_rdata_i,
  output logic             buf_wr_o,
  output logic [7:0]       buf_wdata_o
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} rmw_state_e;
  rmw_state_e state_q;
  logic       done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept_i) begin
          if (fix_i) state_q <= S_RD;
          else       done_q  <= 1'b1;
        end
        S_RD: state_q <= S_WR;
        S_WR: begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = state_q != S_IDLE;
  assign done_o      = done_q;
  assign buf_addr_o  = idx_i;
  assign buf_rd_o    = state_q == S_RD;
  assign buf_wr_o    = state_q == S_WR;
  assign buf_wdata_o = buf_rdata_i ^ mask_i;

  a_r7_wr_after_rd : assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $past(buf_rd_o));
  a_r7_single_flip : assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_wr_o |-> $countones(buf_wdata_o ^ buf_rdata_i) == 1);
  a_r8_done_idle : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/nand_ecc_corrector.sv
module nand_ecc_corrector
  import nand_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      apply_i,
  input  logic [ECC_BYTES-1:0][7:0] stored_ecc_i,
  input  logic [ECC_BYTES-1:0][7:0] calc_ecc_i,
  output logic [1:0]                status_o,
  output logic [OFS_W-1:0]          byte_idx_o,
  output logic [7:0]                bit_mask_o,
  output logic                      done_o,
  output logic                      busy_o,
  output logic [OFS_W-1:0]          buf_addr_o,
  output logic                      buf_rd_o,
  input  logic [7:0]                buf_rdata_i,
  output logic                      buf_wr_o,
  output logic [7:0]                buf_wdata_o
);
  localparam logic [OFS_W:0] LIMIT = SECTOR_BYTES[OFS_W:0];

  logic [ECC_W-1:0] syn;
  ecc_verdict_t     verdict, result_q;
  logic             accept, fix;

  ecc_syndrome u_syn (
    .stored_i (stored_ecc_i),
    .calc_i   (calc_ecc_i),
    .syn_o    (syn)
  );

  ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES)) u_cls (
    .syn_i     (syn),
    .verdict_o (verdict)
  );

  assign accept = start_i && !busy_o;
  assign fix    = apply_i && (verdict.status == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     result_q <= '{status: ST_CLEAN, idx: '0, mask: '0};
    else if (accept) result_q <= verdict;
  end

  ecc_rmw_ctrl u_rmw (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .fix_i       (fix),
    .idx_i       (result_q.idx),
    .mask_i      (result_q.mask),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .buf_addr_o  (buf_addr_o),
    .buf_rd_o    (buf_rd_o),
    .buf_rdata_i (buf_rdata_i),
    .buf_wr_o    (buf_wr_o),
    .buf_wdata_o (buf_wdata_o)
  );

  assign status_o   = result_q.status;
  assign byte_idx_o = result_q.idx;
  assign bit_mask_o = result_q.mask;

  a_r9_busy_ignore : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(status_o) && $stable(byte_idx_o) && $stable(bit_mask_o)));
  a_r3_idx_in_sector : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == ST_DATA) |-> ({1'b0, byte_idx_o} < LIMIT));
  a_r5_access_only_data : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_o || buf_wr_o) |-> (status_o == ST_DATA));
  a_r10_idle_no_strobe : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!buf_rd_o && !buf_wr_o));
endmodule

// File: tb/nand_ecc_corrector_bench.sv
module nand_ecc_corrector_bench;
  localparam int SB = 384;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, apply = 1'b0;
  logic [2:0][7:0] stored = '0, calc = '0;
  logic [1:0]      status;
  logic [8:0]      idx, addr;
  logic [7:0]      mask, rdata_q, wdata;
  logic            done, busy, rd, wr;
  logic [7:0]      mem [512];

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  nand_ecc_corrector #(.SECTOR_BYTES(SB)) u_nand_ecc_corrector (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .apply_i(apply),
    .stored_ecc_i(stored), .calc_ecc_i(calc),
    .status_o(status), .byte_idx_o(idx), .bit_mask_o(mask),
    .done_o(done), .busy_o(busy),
    .buf_addr_o(addr), .buf_rd_o(rd), .buf_rdata_i(rdata_q),
    .buf_wr_o(wr), .buf_wdata_o(wdata)
  );

  // sector buffer model, one-cycle read latency
  always_ff @(posedge clk) begin
    if (rd) rdata_q <= mem[addr];
    if (wr) mem[addr] <= wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] data_syn(input int ofs, input int b);
    logic [11:0] hi;
    hi = 12'((ofs << 3) | b);
    return {hi, ~hi};
  endfunction

  // issue one request; report done cycle and rd/wr cycles relative to accepting edge
  task automatic issue(input logic [23:0] st, input logic [23:0] syn, input logic ap,
                       input logic extra_start,
                       output int done_at, output int rd_at, output int wr_at,
                       output int n_done);
    done_at = 0; rd_at = 0; wr_at = 0; n_done = 0;
    @(negedge clk);
    stored = {st[23:16], st[15:8], st[7:0]};
    calc   = st ^ syn;
    apply  = ap;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      if (done) begin n_done++; if (done_at == 0) done_at = k; end
      if (rd && rd_at == 0) rd_at = k;
      if (wr && wr_at == 0) wr_at = k;
      if (k == 1 && extra_start) begin
        stored = '0; calc = '0; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R10 status", status, 0);
    chk("R10 done", done, 0);
    chk("R10 busy", busy, 0);
    chk("R10 strobes", {rd, wr}, 0);
  endtask

  task automatic t_clean();
    int d, r, w, nd;
    issue(24'hA5C33C, 24'h0, 1'b1, 1'b0, d, r, w, nd);
    chk("R2 status", status, 0);
    chk("R2 idx/mask", {idx, mask}, 0);
    chk("R2 no access", r + w, 0);
    chk("R7 done after 1", d, 1);
    chk("R8 one done", nd, 1);
  endtask

  task automatic t_data_fix();
    int d, r, w, nd;
    logic [7:0] orig5, orig6;
    orig5 = mem[5]; orig6 = mem[6];
    // byte 5 bit 3, bytes given LSB first (R1)
    issue(24'h123456, data_syn(5, 3), 1'b1, 1'b0, d, r, w, nd);
    chk("R1/R3 status", status, 1);
    chk("R3 idx", idx, 5);
    chk("R3 mask", mask, 8'h08);
    chk("R7 rd cycle", r, 1);
    chk("R7 wr cycle", w, 2);
    chk("R7 done cycle", d, 3);
    chk("R7 byte flipped", mem[5], orig5 ^ 8'h08);
    chk("R7 neighbour intact", mem[6], orig6);
    chk("R8 hold idx", idx, 5);
  endtask

  task automatic t_data_report_only();
    int d, r, w, nd;
    logic [7:0] orig;
    orig = mem[0];
    issue(24'hFFFFFF, data_syn(0, 0), 1'b0, 1'b0, d, r, w, nd);
    chk("R3 status lo", status, 1);
    chk("R3 idx lo", idx, 0);
    chk("R3 mask lo", mask, 8'h01);
    chk("R7 no-apply done", d, 1);
    chk("R7 no-apply access", r + w, 0);
    chk("R7 no-apply data", mem[0], orig);
  endtask

  task automatic t_last_byte();
    int d, r, w, nd;
    logic [7:0] orig;
    orig = mem[SB-1];
    issue(24'h00FF00, data_syn(SB-1, 7), 1'b1, 1'b0, d, r, w, nd);
    chk("R3 boundary status", status, 1);
    chk("R3 boundary idx", idx, SB-1);
    chk("R3 boundary mask", mask, 8'h80);
    chk("R7 boundary flip", mem[SB-1], orig ^ 8'h80);
  endtask

  task automatic t_out_of_range();
    int d, r, w, nd;
    issue(24'h0F0F0F, data_syn(SB, 2), 1'b1, 1'b0, d, r, w, nd);
    chk("R4 at limit", status, 3);
    chk("R4 no access", r + w, 0);
    issue(24'h0F0F0F, data_syn(400, 1), 1'b1, 1'b0, d, r, w, nd);
    chk("R4 beyond", status, 3);
    chk("R4 idx/mask", {idx, mask}, 0);
  endtask

  task automatic t_ecc_bit();
    int d, r, w, nd;
    issue(24'h5A5A5A, 24'h000010, 1'b1, 1'b0, d, r, w, nd);
    chk("R5 status", status, 2);
    chk("R5 idx/mask", {idx, mask}, 0);
    chk("R5 no access", r + w, 0);
    issue(24'h5A5A5A, 24'h800000, 1'b1, 1'b0, d, r, w, nd);
    chk("R5 top bit", status, 2);
  endtask

  task automatic t_uncorr();
    int d, r, w, nd;
    issue(24'h314159, 24'h000003, 1'b1, 1'b0, d, r, w, nd);
    chk("R6 two bits", status, 3);
    chk("R6 idx/mask", {idx, mask}, 0);
    issue(24'h314159, 24'h0FFFFF, 1'b1, 1'b0, d, r, w, nd);
    chk("R6 near complement", status, 3);
  endtask

  task automatic t_busy_ignore();
    int d, r, w, nd;
    logic [7:0] orig;
    orig = mem[9];
    // clean request strobed during the read cycle must be dropped
    issue(24'h777777, data_syn(9, 6), 1'b1, 1'b1, d, r, w, nd);
    chk("R9 status kept", status, 1);
    chk("R9 idx kept", idx, 9);
    chk("R9 write still done", mem[9], orig ^ 8'h40);
    chk("R9 single done", nd, 1);
    chk("R9 done cycle", d, 3);
  endtask

  task automatic t_back_to_back();
    int d, r, w, nd;
    // request accepted in the same cycle as the previous done pulse
    @(negedge clk);
    stored = '0; calc = 24'h000100; apply = 1'b1; start = 1'b1;
    @(negedge clk);
    chk("R8 first done", done, 1);
    calc = 24'h000003;
    @(negedge clk);
    start = 1'b0;
    chk("R8 second done", done, 1);
    chk("R8 second status", status, 3);
    @(negedge clk);
    chk("R8 done drops", done, 0);
    chk("R8 status holds", status, 3);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_data_fix();
    t_data_report_only();
    t_last_byte();
    t_out_of_range();
    t_ecc_bit();
    t_uncorr();
    t_busy_ignore();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule